// File: doc/BRIEF.md
# DSP Register Move Datapath

This block holds the architectural register file of a small 16-bit DSP and executes its register-to-register move instruction in one cycle. A move word carries a 4-bit destination index and a 4-bit source index. The register file has a constant all-ones register, two multiplier operands X and Y, a 32-bit accumulator reachable through a high-half and a low-half index, a status word, the program counter, a hardware call stack of fixed depth, and a read-only product register derived from X and Y.

An instruction is offered with `instr_valid` while `instr_ready` is high, and `instr_done` pulses when it has retired. Register indices 8 to 12 and 14 belong to memory-access registers that live outside this block. For those, the block only raises read or write strobes on a stub port, and the outside answers a read in the same cycle on `ext_rdata`. A side-effect-free test port returns any register selected by `dbg_idx`.

Top module: `dsp_move_unit`

## Requirements
- R1: A word is a move only when bits 15:9 are all zero; the destination index is bits 7:4 and the source index is bits 3:0. A non-move word, a source or destination index of 13, or a destination index of 7 completes with no register, stack or stub effect, and `anomaly` is high for the one cycle in which `instr_done` is high.
- R2: The all-zero word completes as a no-operation that changes no register.
- R3: Index 0 reads as 0xFFFF, and a move whose destination index is 0 changes nothing and raises no anomaly.
- R4: The accumulator is 32 bits wide. Index 3 reads and writes bits 31:16, and index 15 reads and writes bits 15:0; each write leaves the other half unchanged.
- R5: Reading index 7 gives bits 31:16 of (X × Y × 2), with X and Y taken as unsigned and the result truncated to 32 bits. The value uses the X and Y held before the instruction.
- R6: The word 0x0037 (destination 3, source 7) loads the full 32-bit product into the accumulator.
- R7: After reset the program counter is 0x0400. A move that writes index 6 drops `instr_ready` for one cycle, and `instr_done` comes one cycle later than for other moves.
- R8: The call stack (index 5) holds 6 entries and its pointer resets to 6. A write decrements the pointer and then stores the value. A read returns the entry at the pointer and then increments it, so values come back last-in, first-out.
- R9: A stack write with the pointer at 0 stores nothing and pulses `stk_ovf`. A stack read with the pointer at 6 returns 0 and pulses `stk_unf`. Both pulses line up with `instr_done`.
- R10: A valid move whose source index is 8 to 12 or 14 raises `ext_rd` with that index on `ext_rd_idx` and takes `ext_rdata`. A destination in that set raises `ext_wr` with the index on `ext_wr_idx` and the moved value on `ext_wdata`. These strobes are high only in the accept cycle.
- R11: Except for a program counter write, `instr_done` is high in the cycle right after the accepting clock edge.
- R12: `dbg_data` shows register `dbg_idx` without side effects. Index 5 shows the stack pointer, index 7 the product high half, and indices 8 to 14 show 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 16 | Instruction word |
| instr_ready | output | 1 | Block can take an instruction this cycle |
| instr_done | output | 1 | Instruction retired (one-cycle pulse) |
| anomaly | output | 1 | Retired instruction had no defined effect |
| stk_ovf | output | 1 | Stack write was refused |
| stk_unf | output | 1 | Stack read found the stack empty |
| ext_rd | output | 1 | Stub read strobe |
| ext_rd_idx | output | 4 | Register index being read on the stub |
| ext_rdata | input | 16 | Same-cycle read data from the stub |
| ext_wr | output | 1 | Stub write strobe |
| ext_wr_idx | output | 4 | Register index being written on the stub |
| ext_wdata | output | 16 | Stub write data |
| dbg_idx | input | 4 | Test port register select |
| dbg_data | output | 16 | Test port register value |

## Verification
The stub strobes and `ext_wdata` are combinational in the accept cycle, so the bench samples them a nanosecond after it drives the word and before the clock edge. Register contents, `instr_done`, `anomaly` and the stack flags change at the accepting edge, so the bench samples them at the next falling edge. For a program counter write, the bench first sees `instr_done` low and `instr_ready` low at that falling edge, and sees `instr_done` high one full cycle later. The test port is combinational, so register contents are read a nanosecond after `dbg_idx` is set, with no instruction in flight.

// File: rtl/dsp_mv_pkg.sv
package dsp_mv_pkg;
   typedef enum logic [3:0] {
      RI_ONES  = 4'd0,
      RI_X     = 4'd1,
      RI_Y     = 4'd2,
      RI_ACCHI = 4'd3,
      RI_STAT  = 4'd4,
      RI_STK   = 4'd5,
      RI_PC    = 4'd6,
      RI_PROD  = 4'd7,
      RI_MA0   = 4'd8,
      RI_MA1   = 4'd9,
      RI_MA2   = 4'd10,
      RI_MA3   = 4'd11,
      RI_MA4   = 4'd12,
      RI_HOLE  = 4'd13,
      RI_MCTL  = 4'd14,
      RI_ACCLO = 4'd15
   } reg_idx_e;

   typedef struct packed {
      logic     acc_from_prod;
      logic     src_ext;
      logic     dst_ext;
      logic     bad;
      reg_idx_e dst;
      reg_idx_e src;
   } mv_dec_t;

   function automatic logic idx_is_ext(input reg_idx_e i);
      return ((i >= RI_MA0) && (i <= RI_MA4)) || (i == RI_MCTL);
   endfunction
endpackage

// File: rtl/dsp_mv_decode.sv
module dsp_mv_decode
   import dsp_mv_pkg::*;
(
   input  logic [15:0] word,
   output mv_dec_t     dec
);
   logic is_move;

   always_comb begin
      is_move           = (word[15:9] == 7'd0) && (word[8] == 1'b0 || word[8] == 1'b1);
      dec.dst           = reg_idx_e'(word[7:4]);
      dec.src           = reg_idx_e'(word[3:0]);
      dec.acc_from_prod = is_move && (dec.dst == RI_ACCHI) && (dec.src == RI_PROD);
      dec.src_ext       = idx_is_ext(dec.src);
      dec.dst_ext       = idx_is_ext(dec.dst);
      dec.bad           = !is_move || (dec.src == RI_HOLE) || (dec.dst == RI_HOLE)
                          || (dec.dst == RI_PROD);
   end
endmodule

// File: rtl/dsp_mv_product.sv
module dsp_mv_product #(
   parameter int DW         = 16,
   parameter bit SIGNED_MUL = 1'b0
) (
   input  logic [DW-1:0]   x,
   input  logic [DW-1:0]   y,
   output logic [2*DW-1:0] prod
);
   localparam int PW = 2 * DW;
   logic [PW-1:0] raw;

   generate
      if (SIGNED_MUL) begin : g_signed
         assign raw = PW'($signed(x) * $signed(y));
      end else begin : g_unsigned
         assign raw = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
      end
   endgenerate

   assign prod = {raw[PW-2:0], 1'b0};
endmodule

// File: rtl/dsp_mv_stack.sv
module dsp_mv_stack #(
   parameter int DW    = 16,
   parameter int DEPTH = 6,
   localparam int SPW  = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pop,
   input  logic           push,
   input  logic [DW-1:0]  push_data,
   output logic [DW-1:0]  pop_data,
   output logic [SPW-1:0] sp,
   output logic           ovf,
   output logic           unf
);
   logic [DW-1:0]  mem [DEPTH];
   logic [DW-1:0]  rd;
   logic [SPW-1:0] sp_mid;
   logic           pop_ok, push_ok;

   always_comb begin
      rd = '0;
      for (int i = 0; i < DEPTH; i++)
         if (sp == SPW'(i)) rd = mem[i];
      pop_ok   = pop && (sp != SPW'(DEPTH));
      sp_mid   = pop_ok ? sp + SPW'(1) : sp;
      push_ok  = push && (sp_mid != '0);
      pop_data = pop_ok ? rd : '0;
      ovf      = push && !push_ok;
      unf      = pop && !pop_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= SPW'(DEPTH);
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         sp <= push_ok ? sp_mid - SPW'(1) : sp_mid;
         for (int i = 0; i < DEPTH; i++)
            if (push_ok && (sp_mid == SPW'(i + 1))) mem[i] <= push_data;
      end
   end
endmodule

// File: rtl/dsp_move_unit.sv
module dsp_move_unit
   import dsp_mv_pkg::*;
#(
   parameter int          DW          = 16,
   parameter int          STACK_DEPTH = 6,
   parameter logic [15:0] PC_RESET    = 16'h0400,
   parameter bit          SIGNED_MUL  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          instr_valid,
   input  logic [15:0]   instr_word,
   output logic          instr_ready,
   output logic          instr_done,
   output logic          anomaly,
   output logic          stk_ovf,
   output logic          stk_unf,
   output logic          ext_rd,
   output logic [3:0]    ext_rd_idx,
   input  logic [DW-1:0] ext_rdata,
   output logic          ext_wr,
   output logic [3:0]    ext_wr_idx,
   output logic [DW-1:0] ext_wdata,
   input  logic [3:0]    dbg_idx,
   output logic [DW-1:0] dbg_data
);
   localparam int SPW = $clog2(STACK_DEPTH + 1);
   localparam int AW  = 2 * DW;

   generate
      if (DW < 16) begin : g_bad_dw
         $error("dsp_move_unit: DW must be at least 16");
      end
      if (STACK_DEPTH < 1) begin : g_bad_depth
         $error("dsp_move_unit: STACK_DEPTH must be at least 1");
      end
   endgenerate

   mv_dec_t        dec;
   logic [DW-1:0]  x_q, y_q, st_q, pc_q, rd_val, stk_rd;
   logic [AW-1:0]  acc_q, prod;
   logic [SPW-1:0] stk_sp;
   logic           busy_q, done_q, anom_q, ovf_q, unf_q;
   logic           accept, act, pc_wr, stk_pop, stk_push, ovf_c, unf_c;

   dsp_mv_decode u_dec (.word(instr_word), .dec(dec));

   dsp_mv_product #(.DW(DW), .SIGNED_MUL(SIGNED_MUL)) u_prod (
      .x(x_q), .y(y_q), .prod(prod));

   assign accept   = instr_valid && !busy_q;
   assign act      = accept && !dec.bad;
   assign pc_wr    = act && (dec.dst == RI_PC);
   assign stk_pop  = act && (dec.src == RI_STK) && !dec.acc_from_prod;
   assign stk_push = act && (dec.dst == RI_STK);

   dsp_mv_stack #(.DW(DW), .DEPTH(STACK_DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .pop(stk_pop), .push(stk_push),
      .push_data(rd_val), .pop_data(stk_rd), .sp(stk_sp),
      .ovf(ovf_c), .unf(unf_c));

   always_comb begin
      unique case (dec.src)
         RI_ONES:  rd_val = '1;
         RI_X:     rd_val = x_q;
         RI_Y:     rd_val = y_q;
         RI_ACCHI: rd_val = acc_q[AW-1:DW];
         RI_STAT:  rd_val = st_q;
         RI_STK:   rd_val = stk_rd;
         RI_PC:    rd_val = pc_q;
         RI_PROD:  rd_val = prod[AW-1:DW];
         RI_ACCLO: rd_val = acc_q[DW-1:0];
         RI_HOLE:  rd_val = '0;
         default:  rd_val = ext_rdata;
      endcase
   end

   assign ext_rd     = act && dec.src_ext;
   assign ext_rd_idx = dec.src;
   assign ext_wr     = act && dec.dst_ext;
   assign ext_wr_idx = dec.dst;
   assign ext_wdata  = rd_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q   <= '0;
         y_q   <= '0;
         st_q  <= '0;
         acc_q <= '0;
         pc_q  <= DW'(PC_RESET);
      end else if (act) begin
         if (dec.acc_from_prod) acc_q <= prod;
         else begin
            unique case (dec.dst)
               RI_X:     x_q <= rd_val;
               RI_Y:     y_q <= rd_val;
               RI_ACCHI: acc_q[AW-1:DW] <= rd_val;
               RI_STAT:  st_q <= rd_val;
               RI_PC:    pc_q <= rd_val;
               RI_ACCLO: acc_q[DW-1:0] <= rd_val;
               default:  ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         anom_q <= 1'b0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         busy_q <= pc_wr;
         done_q <= (accept && !pc_wr) || busy_q;
         anom_q <= accept && dec.bad;
         ovf_q  <= ovf_c;
         unf_q  <= unf_c;
      end
   end

   assign instr_ready = !busy_q;
   assign instr_done  = done_q;
   assign anomaly     = anom_q;
   assign stk_ovf     = ovf_q;
   assign stk_unf     = unf_q;

   always_comb begin
      unique case (reg_idx_e'(dbg_idx))
         RI_ONES:  dbg_data = '1;
         RI_X:     dbg_data = x_q;
         RI_Y:     dbg_data = y_q;
         RI_ACCHI: dbg_data = acc_q[AW-1:DW];
         RI_STAT:  dbg_data = st_q;
         RI_STK:   dbg_data = DW'(stk_sp);
         RI_PC:    dbg_data = pc_q;
         RI_PROD:  dbg_data = prod[AW-1:DW];
         RI_ACCLO: dbg_data = acc_q[DW-1:0];
         default:  dbg_data = '0;
      endcase
   end
endmodule

// File: rtl/dsp_move_unit_chk.sv
module dsp_move_unit_chk #(
   parameter int DW    = 16,
   parameter int SPW   = 3,
   parameter int DEPTH = 6
) (
   input logic           clk,
   input logic           rst_n,
   input logic           instr_valid,
   input logic           instr_ready,
   input logic [15:0]    instr_word,
   input logic           instr_done,
   input logic           anomaly,
   input logic           stk_ovf,
   input logic           stk_unf,
   input logic [SPW-1:0] sp,
   input logic [DW-1:0]  x_q,
   input logic [3:0]     dbg_idx,
   input logic [DW-1:0]  dbg_data
);
   logic acc_now, pcw_now;
   assign acc_now = instr_valid && instr_ready;
   assign pcw_now = acc_now && (instr_word[15:9] == 7'd0) && (instr_word[7:4] == 4'd6)
                    && (instr_word[3:0] != 4'd13);

   p_anom_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      anomaly |-> instr_done);

   p_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && instr_word == 16'd0) |=> ($stable(x_q) && $stable(sp)));

   p_reg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_idx == 4'd0) |-> (dbg_data == {DW{1'b1}}));

   p_pc_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pcw_now |=> (!instr_ready && !instr_done));

   p_sp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sp <= SPW'(DEPTH));

   p_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stk_ovf |-> (sp == '0 && instr_done));

   p_unf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stk_unf |-> (sp == SPW'(DEPTH) && instr_done));

   p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_now && !pcw_now) |=> instr_done);
endmodule

bind dsp_move_unit dsp_move_unit_chk #(.DW(DW), .SPW(SPW), .DEPTH(STACK_DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
   .instr_word(instr_word), .instr_done(instr_done), .anomaly(anomaly),
   .stk_ovf(stk_ovf), .stk_unf(stk_unf), .sp(stk_sp), .x_q(x_q),
   .dbg_idx(dbg_idx), .dbg_data(dbg_data));

// File: tb/tb_dsp_move_unit.sv
module tb_dsp_move_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr_word = '0;
   logic        instr_ready, instr_done, anomaly, stk_ovf, stk_unf;
   logic        ext_rd, ext_wr;
   logic [3:0]  ext_rd_idx, ext_wr_idx;
   logic [15:0] ext_rdata = '0;
   logic [15:0] ext_wdata;
   logic [3:0]  dbg_idx = '0;
   logic [15:0] dbg_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic        c_rd, c_wr, c_done, c_anom, c_ovf, c_unf, c_ready;
   logic [3:0]  c_rd_idx, c_wr_idx;
   logic [15:0] c_wdata;

   always #4 clk = ~clk;

   dsp_move_unit dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .instr_ready(instr_ready), .instr_done(instr_done), .anomaly(anomaly),
      .stk_ovf(stk_ovf), .stk_unf(stk_unf), .ext_rd(ext_rd), .ext_rd_idx(ext_rd_idx),
      .ext_rdata(ext_rdata), .ext_wr(ext_wr), .ext_wr_idx(ext_wr_idx),
      .ext_wdata(ext_wdata), .dbg_idx(dbg_idx), .dbg_data(dbg_data));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] w, input logic [15:0] ed);
      @(negedge clk);
      instr_word  = w;
      ext_rdata   = ed;
      instr_valid = 1'b1;
      #1;
      c_rd = ext_rd; c_rd_idx = ext_rd_idx;
      c_wr = ext_wr; c_wr_idx = ext_wr_idx; c_wdata = ext_wdata;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      instr_word  = '0;
      c_done = instr_done; c_anom = anomaly; c_ovf = stk_ovf;
      c_unf = stk_unf; c_ready = instr_ready;
   endtask

   task automatic peek(input logic [3:0] idx, output logic [15:0] v);
      dbg_idx = idx;
      #1;
      v = dbg_data;
   endtask

   task automatic load_x(input logic [15:0] v);
      issue(16'h0018, v);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      check("R7 ready after reset", {31'd0, instr_ready}, 32'd1);
      check("R11 no done after reset", {31'd0, instr_done}, 32'd0);
      peek(4'd6, v); check("R7 pc reset", {16'd0, v}, 32'h0400);
      peek(4'd5, v); check("R8 sp reset", {16'd0, v}, 32'd6);
      peek(4'd1, v); check("R12 x reset", {16'd0, v}, 32'd0);
      peek(4'd0, v); check("R3 reg0 reads ones", {16'd0, v}, 32'hFFFF);
   endtask

   task automatic t_reg0_nop;
      logic [15:0] v;
      issue(16'h0010, 16'h0000);
      peek(4'd1, v); check("R3 x from reg0", {16'd0, v}, 32'hFFFF);
      check("R11 done one cycle after accept", {31'd0, c_done}, 32'd1);
      load_x(16'h1357);
      issue(16'h0001, 16'h0);
      check("R3 write reg0 no anomaly", {31'd0, c_anom}, 32'd0);
      peek(4'd0, v); check("R3 reg0 still ones", {16'd0, v}, 32'hFFFF);
      issue(16'h0000, 16'h0);
      check("R2 nop done", {31'd0, c_done}, 32'd1);
      check("R2 nop no anomaly", {31'd0, c_anom}, 32'd0);
      peek(4'd1, v); check("R2 nop x unchanged", {16'd0, v}, 32'h1357);
      peek(4'd5, v); check("R2 nop sp unchanged", {16'd0, v}, 32'd6);
   endtask

   task automatic t_product;
      logic [15:0] v;
      load_x(16'h8001);
      issue(16'h0028, 16'h0003);
      peek(4'd7, v); check("R5 product hi", {16'd0, v}, 32'h0003);
      issue(16'h0047, 16'h0);
      peek(4'd4, v); check("R5 st from product", {16'd0, v}, 32'h0003);
      issue(16'h0037, 16'h0);
      peek(4'd3, v); check("R6 acc hi from product", {16'd0, v}, 32'h0003);
      peek(4'd15, v); check("R6 acc lo from product", {16'd0, v}, 32'h0006);
      load_x(16'hFFFF);
      issue(16'h0028, 16'hFFFF);
      peek(4'd7, v); check("R5 unsigned truncated", {16'd0, v}, 32'hFFFC);
      issue(16'h0037, 16'h0);
      peek(4'd15, v); check("R6 lo of large product", {16'd0, v}, 32'h0002);
      issue(16'h0071, 16'h0);
      check("R5 write to product is anomaly", {31'd0, c_anom}, 32'd1);
      peek(4'd7, v); check("R5 product unchanged", {16'd0, v}, 32'hFFFC);
   endtask

   task automatic t_acc_halves;
      logic [15:0] v;
      issue(16'h00F8, 16'hBEEF);
      peek(4'd15, v); check("R4 lo write", {16'd0, v}, 32'hBEEF);
      peek(4'd3, v); check("R4 hi kept", {16'd0, v}, 32'hFFFC);
      issue(16'h0038, 16'h1234);
      peek(4'd3, v); check("R4 hi write", {16'd0, v}, 32'h1234);
      peek(4'd15, v); check("R4 lo kept", {16'd0, v}, 32'hBEEF);
      issue(16'h001F, 16'h0);
      peek(4'd1, v); check("R4 read lo into x", {16'd0, v}, 32'hBEEF);
   endtask

   task automatic t_stack;
      logic [15:0] v;
      for (int i = 0; i < 6; i++) begin
         load_x(16'h1100 + 16'(i));
         issue(16'h0051, 16'h0);
         check("R9 no overflow while filling", {31'd0, c_ovf}, 32'd0);
      end
      peek(4'd5, v); check("R8 sp after six pushes", {16'd0, v}, 32'd0);
      load_x(16'h7777);
      issue(16'h0051, 16'h0);
      check("R9 overflow flag", {31'd0, c_ovf}, 32'd1);
      peek(4'd5, v); check("R9 sp stays 0", {16'd0, v}, 32'd0);
      for (int i = 5; i >= 0; i--) begin
         issue(16'h0025, 16'h0);
         peek(4'd2, v); check("R8 lifo pop order", {16'd0, v}, 32'h1100 + 32'(i));
         check("R9 no underflow while draining", {31'd0, c_unf}, 32'd0);
      end
      issue(16'h0025, 16'h0);
      check("R9 underflow flag", {31'd0, c_unf}, 32'd1);
      peek(4'd2, v); check("R9 empty pop returns 0", {16'd0, v}, 32'd0);
      peek(4'd5, v); check("R9 sp stays 6", {16'd0, v}, 32'd6);
   endtask

   task automatic t_pc;
      logic [15:0] v;
      load_x(16'h0123);
      issue(16'h0061, 16'h0);
      check("R7 pc write no done yet", {31'd0, c_done}, 32'd0);
      check("R7 pc write ready low", {31'd0, c_ready}, 32'd0);
      @(negedge clk);
      check("R7 pc write done late", {31'd0, instr_done}, 32'd1);
      check("R7 ready back", {31'd0, instr_ready}, 32'd1);
      peek(4'd6, v); check("R7 pc value", {16'd0, v}, 32'h0123);
      issue(16'h0026, 16'h0);
      peek(4'd2, v); check("R12 y from pc", {16'd0, v}, 32'h0123);
   endtask

   task automatic t_anomaly;
      logic [15:0] v;
      load_x(16'h4242);
      issue(16'h00D1, 16'h0);
      check("R1 dst 13 anomaly", {31'd0, c_anom}, 32'd1);
      issue(16'h001D, 16'h0);
      check("R1 src 13 anomaly", {31'd0, c_anom}, 32'd1);
      peek(4'd1, v); check("R1 src 13 no effect", {16'd0, v}, 32'h4242);
      issue(16'h0218, 16'h9999);
      check("R1 non-move anomaly", {31'd0, c_anom}, 32'd1);
      check("R1 non-move no stub read", {31'd0, c_rd}, 32'd0);
      peek(4'd1, v); check("R1 non-move no effect", {16'd0, v}, 32'h4242);
      issue(16'h0011, 16'h0);
      check("R1 anomaly cleared", {31'd0, c_anom}, 32'd0);
   endtask

   task automatic t_ext;
      logic [15:0] v;
      load_x(16'h5A5A);
      issue(16'h00A1, 16'h0);
      check("R10 write strobe", {31'd0, c_wr}, 32'd1);
      check("R10 write index", {28'd0, c_wr_idx}, 32'd10);
      check("R10 write data", {16'd0, c_wdata}, 32'h5A5A);
      check("R10 no read strobe", {31'd0, c_rd}, 32'd0);
      issue(16'h00E9, 16'hC0DE);
      check("R10 read strobe", {31'd0, c_rd}, 32'd1);
      check("R10 read index", {28'd0, c_rd_idx}, 32'd9);
      check("R10 forwarded data", {16'd0, c_wdata}, 32'hC0DE);
      check("R10 write index 14", {28'd0, c_wr_idx}, 32'd14);
      #1;
      check("R10 strobes drop", {30'd0, ext_rd, ext_wr}, 32'd0);
      peek(4'd9, v); check("R12 stub index reads 0", {16'd0, v}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg0_nop();
      t_product();
      t_acc_halves();
      t_stack();
      t_pc();
      t_anomaly();
      t_ext();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule